// File: doc/BRIEF.md
# Partial-Reconfiguration Handshake Sequencer

This block runs the whole partial-reconfiguration exchange with the fabric's configuration port in hardware, so software does not have to sequence it. A one-cycle `start` launches a run. The block first checks the mode-select and configuration-pin levels. It then takes in the image header from a valid/ready word stream and stores it. From two flag fields in the header it picks the clock-to-data ratio for a 16-bit configuration width.

Once the header is stored, the block drives the port-control lines through a fixed setup order. The order includes two clock-flush bursts, which a separate pin streamer executes on request. The block then polls for the fabric's ready flag and replays the stored header. It passes the rest of the image through unchanged and polls for the completion flag. Whatever the outcome of the polls, it runs a fixed teardown once setup has finished.

At the end it reports a two-bit result code together with a one-cycle `done` pulse.

Top module: `pr_sequencer`

## Requirements
- R1: A start is refused with result 1 (invalid), and no port-control line moves, unless `mode_sel` is 000 or 001 and both `cfg_n_in` and `stat_n_in` are high.
- R2: A start with `full_mode` high (full, non-partial configuration) is refused with result 1 and moves no port-control line.
- R3: The first 230 image words (indices 0..229) are stored as the header. Word 69 marks encryption when its bits [3:2] are nonzero. Word 229 marks compression when its bit 1 is zero. A stream whose `img_last` arrives before word 229 ends the run with result 1 and moves no port-control line.
- R4: `clk_ratio` is 0 (x1) when the image is neither encrypted nor compressed, 1 (x2) when only encrypted, and 2 (x4) when compressed, with or without encryption.
- R5: Setup runs in this order, one change at a time: `chip_en_n` low with `pr_request` and `port_own` low; `drive_en` high; `pin_release` high; `port_own` high; a 256-clock flush burst; `pr_request` high; a 2047-clock flush burst.
- R6: Image words reach `out_data` only while the request session is open and after `pr_rdy` has been seen. The stored header words come first and unchanged, followed by the remaining stream words in order.
- R7: The ready poll takes one status sample per cycle, for at most 10 samples. `pr_err` is checked before `pr_rdy` and gives result 3. Ready on any of the 10 samples proceeds. No ready gives result 2 (timeout).
- R8: After the last word is forwarded, the completion poll takes at most 10 samples, with the same priority. Error gives 3, `pr_fin` proceeds, and no completion gives 2.
- R9: Teardown runs after every completed setup, whether the polls succeeded or not. Its order is: `pr_request` low; a 256-clock flush burst; `drive_en` low; `chip_en_n` high; `port_own` low.
- R10: After teardown without an earlier error, the result is 0 if `user_mode`, `cfg_done_in` and `stat_n_in` are all high, else 2. An earlier error code is kept.
- R11: `done` is a one-cycle pulse, and `result` holds its value between pulses. A `start` while `busy` is high is ignored.
- R12: After reset, `chip_en_n` is high, `drive_en`, `pin_release`, `port_own`, `pr_request`, `flush_req`, `busy` and `done` are low, and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle run request |
| full_mode | input | 1 | High requests full (non-partial) configuration, which is refused |
| mode_sel | input | 3 | Mode-select pin levels |
| cfg_n_in | input | 1 | Configuration-reset pin level (active low) |
| stat_n_in | input | 1 | Status pin level (active low) |
| cfg_done_in | input | 1 | Configuration-done pin level |
| user_mode | input | 1 | Fabric is in user mode |
| pr_rdy | input | 1 | Fabric ready to take partial image data |
| pr_fin | input | 1 | Fabric finished the partial image |
| pr_err | input | 1 | Fabric reports a partial-reconfiguration error |
| img_valid | input | 1 | Image word valid |
| img_data | input | DW | Image word |
| img_last | input | 1 | Marks the final image word |
| img_ready | output | 1 | Image word accepted |
| out_valid | output | 1 | Word valid toward the pin streamer |
| out_data | output | DW | Word toward the pin streamer |
| out_ready | input | 1 | Pin streamer accepts the word |
| flush_req | output | 1 | Requests a clock-flush burst, held until acknowledged |
| flush_len | output | CW | Burst length in clocks |
| flush_ack | input | 1 | One-cycle burst completion |
| chip_en_n | output | 1 | Configuration chip enable, active low |
| drive_en | output | 1 | Enables clock/data drive to the port |
| pin_release | output | 1 | Releases pin overrides, holding the reset pin inactive |
| port_own | output | 1 | Routes data, clock, enable and request to the port |
| pr_request | output | 1 | Partial-reconfiguration request |
| clk_ratio | output | 2 | Clock-to-data ratio code |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 ok, 1 invalid, 2 timeout, 3 error |

## Verification
Runs are tried with bad mode-select or pin levels and with a full-mode request, which separates the precondition refusal from the rest of the flow. Short streams show that an early end of the image is rejected before any port line moves. Headers with each combination of the two flags separate the ratio choices. Ready arriving on the tenth versus the eleventh sample pins down the poll bound, and an error raised together with ready shows the error check wins. Failures during the completion poll and in the final pin check confirm that teardown still runs and which code survives.

// File: rtl/pr_sequencer.sv
module pr_sequencer #(
  parameter int DW          = 32,
  parameter int HDR_WORDS   = 230,
  parameter int ENC_IDX     = 69,
  parameter int CMP_IDX     = 229,
  parameter int POLL_MAX    = 10,
  parameter int CW          = 12,
  parameter int FLUSH_SHORT = 256,
  parameter int FLUSH_LONG  = 2047
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          full_mode,
  input  logic [2:0]    mode_sel,
  input  logic          cfg_n_in,
  input  logic          stat_n_in,
  input  logic          cfg_done_in,
  input  logic          user_mode,
  input  logic          pr_rdy,
  input  logic          pr_fin,
  input  logic          pr_err,
  input  logic          img_valid,
  input  logic [DW-1:0] img_data,
  input  logic          img_last,
  output logic          img_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic          flush_req,
  output logic [CW-1:0] flush_len,
  input  logic          flush_ack,
  output logic          chip_en_n,
  output logic          drive_en,
  output logic          pin_release,
  output logic          port_own,
  output logic          pr_request,
  output logic [1:0]    clk_ratio,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result
);

  localparam int HW = $clog2(HDR_WORDS);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [1:0] RES_OK  = 2'd0;
  localparam logic [1:0] RES_INV = 2'd1;
  localparam logic [1:0] RES_TO  = 2'd2;
  localparam logic [1:0] RES_ERR = 2'd3;

  typedef enum logic [4:0] {
    IDLE, CHECK, HDR, S_CE, S_DRV, S_REL, S_OWN, S_FL1, S_REQ, S_FL2,
    W_RDY, REPLAY, PASS, W_FIN, T_REQ, T_FL, T_DRV, T_CE, T_OWN, FINAL
  } st_t;

  st_t            st;
  logic [HW-1:0]  idx;
  logic [PW-1:0]  pcnt;
  logic           enc, cmp, hlast;
  logic [1:0]     err;
  logic [DW-1:0]  hbuf [HDR_WORDS];

  function automatic logic [1:0] pick_ratio(input logic e, input logic c, input logic wide);
    if (!e && !c) return 2'd0;
    return (c ? 2'd2 : 2'd1) + {1'b0, wide};
  endfunction

  assign busy      = (st != IDLE);
  assign flush_req = (st == S_FL1) || (st == S_FL2) || (st == T_FL);
  assign flush_len = (st == S_FL2) ? CW'(FLUSH_LONG) : CW'(FLUSH_SHORT);
  assign img_ready = (st == HDR) || ((st == PASS) && out_ready);
  assign out_valid = (st == REPLAY) || ((st == PASS) && img_valid);
  assign out_data  = (st == REPLAY) ? hbuf[idx] : img_data;

  always_ff @(posedge clk)
    if (st == HDR && img_valid) hbuf[idx] <= img_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      idx         <= '0;
      pcnt        <= '0;
      enc         <= 1'b0;
      cmp         <= 1'b0;
      hlast       <= 1'b0;
      err         <= RES_OK;
      result      <= RES_OK;
      done        <= 1'b0;
      chip_en_n   <= 1'b1;
      drive_en    <= 1'b0;
      pin_release <= 1'b0;
      port_own    <= 1'b0;
      pr_request  <= 1'b0;
      clk_ratio   <= 2'd0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) st <= CHECK;
        CHECK: begin
          err   <= RES_OK;
          idx   <= '0;
          hlast <= 1'b0;
          if (full_mode || mode_sel > 3'd1 || !cfg_n_in || !stat_n_in) begin
            result <= RES_INV;
            done   <= 1'b1;
            st     <= IDLE;
          end else begin
            st <= HDR;
          end
        end
        HDR: if (img_valid) begin
          if (idx == HW'(ENC_IDX)) enc <= |img_data[3:2];
          if (idx == HW'(CMP_IDX)) cmp <= ~img_data[1];
          if (idx == HW'(HDR_WORDS - 1)) begin
            hlast <= img_last;
            idx   <= '0;
            st    <= S_CE;
          end else if (img_last) begin
            result <= RES_INV;
            done   <= 1'b1;
            st     <= IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_CE: begin
          clk_ratio  <= pick_ratio(enc, cmp, 1'b0);
          chip_en_n  <= 1'b0;
          pr_request <= 1'b0;
          port_own   <= 1'b0;
          st         <= S_DRV;
        end
        S_DRV: begin drive_en <= 1'b1;    st <= S_REL; end
        S_REL: begin pin_release <= 1'b1; st <= S_OWN; end
        S_OWN: begin port_own <= 1'b1;    st <= S_FL1; end
        S_FL1: if (flush_ack) st <= S_REQ;
        S_REQ: begin pr_request <= 1'b1;  st <= S_FL2; end
        S_FL2: if (flush_ack) begin pcnt <= '0; st <= W_RDY; end
        W_RDY: begin
          if (pr_err) begin
            err <= RES_ERR;
            st  <= T_REQ;
          end else if (pr_rdy) begin
            idx <= '0;
            st  <= REPLAY;
          end else if (pcnt == PW'(POLL_MAX - 1)) begin
            err <= RES_TO;
            st  <= T_REQ;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        REPLAY: if (out_ready) begin
          if (idx == HW'(HDR_WORDS - 1)) begin
            pcnt <= '0;
            st   <= hlast ? W_FIN : PASS;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PASS: if (img_valid && out_ready && img_last) begin
          pcnt <= '0;
          st   <= W_FIN;
        end
        W_FIN: begin
          if (pr_err) begin
            err <= RES_ERR;
            st  <= T_REQ;
          end else if (pr_fin) begin
            st <= T_REQ;
          end else if (pcnt == PW'(POLL_MAX - 1)) begin
            err <= RES_TO;
            st  <= T_REQ;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        T_REQ: begin pr_request <= 1'b0; st <= T_FL; end
        T_FL:  if (flush_ack) st <= T_DRV;
        T_DRV: begin drive_en <= 1'b0;   st <= T_CE; end
        T_CE:  begin chip_en_n <= 1'b1;  st <= T_OWN; end
        T_OWN: begin port_own <= 1'b0;   st <= FINAL; end
        FINAL: begin
          if (err != RES_OK)
            result <= err;
          else
            result <= (user_mode && cfg_done_in && stat_n_in) ? RES_OK : RES_TO;
          done <= 1'b1;
          st   <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pr_sequencer_chk.sv
module pr_sequencer_chk #(
  parameter int CW    = 12,
  parameter int SHORT = 256,
  parameter int LONG  = 2047
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [1:0]    result,
  input logic          chip_en_n,
  input logic          drive_en,
  input logic          pin_release,
  input logic          port_own,
  input logic          pr_request,
  input logic          out_valid,
  input logic          flush_req,
  input logic [CW-1:0] flush_len,
  input logic          flush_ack
);

  // R6
  data_in_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pr_request && drive_en && port_own && !chip_en_n);

  // R5
  req_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pr_request |-> drive_en && port_own && pin_release && !chip_en_n);

  // R5
  long_flush_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pr_request) |-> flush_req && flush_len == CW'(LONG));

  // R9
  short_flush_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pr_request) |-> flush_req && flush_len == CW'(SHORT));

  // R5
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack |=> flush_req && $stable(flush_len));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

bind pr_sequencer pr_sequencer_chk #(.CW(CW), .SHORT(FLUSH_SHORT), .LONG(FLUSH_LONG)) u_chk (.*);

// File: tb/sim_pr_sequencer.sv
module sim_pr_sequencer;
  localparam int DW = 32;
  localparam int CW = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, full_mode, cfg_n_in, stat_n_in, cfg_done_in, user_mode;
  logic [2:0] mode_sel;
  logic pr_rdy, pr_fin, pr_err;
  logic img_valid, img_last, img_ready, out_valid, out_ready;
  logic [DW-1:0] img_data, out_data;
  logic flush_req, flush_ack;
  logic [CW-1:0] flush_len;
  logic chip_en_n, drive_en, pin_release, port_own, pr_request;
  logic [1:0] clk_ratio, result;
  logic busy, done;

  pr_sequencer u0 (.*);

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // fabric model
  bit rdy_en, err_rdy, done_lvl, err_done, fwd_all;
  int rdy_at, err_at, rq_cyc = 0;
  always @(posedge clk)
    if (!pr_request || flush_req) rq_cyc <= 0; else rq_cyc <= rq_cyc + 1;
  assign pr_rdy = rdy_en && pr_request && !flush_req && (rq_cyc >= rdy_at);
  assign pr_err = (err_rdy && pr_request && !flush_req && (rq_cyc >= err_at)) || (err_done && fwd_all);
  assign pr_fin = done_lvl && fwd_all;

  // flush streamer model and event log
  int ev_q[$];
  int ex_q[$];
  bit ack_r = 1'b0;
  int bc = 0;
  assign flush_ack = ack_r;
  always @(posedge clk) begin
    if (ack_r) ack_r <= 1'b0;
    else if (flush_req) begin
      if (bc == 3) begin
        ack_r <= 1'b1;
        bc    <= 0;
        ev_q.push_back(32'h1000 | int'(flush_len));
      end else bc <= bc + 1;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = ((cyc % 5) != 2);
  end

  // monitors
  logic [4:0] ctl_last = 5'b10000;
  logic [31:0] exp_q[$];
  int fwd_n, fwd_tot, done_cnt;
  logic [1:0] last_res;
  always @(negedge clk) if (rst_n) begin
    logic [4:0] c;
    c = {chip_en_n, drive_en, pin_release, port_own, pr_request};
    if (c != ctl_last) begin ev_q.push_back(int'(c)); ctl_last = c; end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected word", out_data, 0);
      else begin
        logic [31:0] w;
        w = exp_q.pop_front();
        chk(out_data == w, "R6", "forwarded word", out_data, w);
      end
      fwd_n++;
      if (fwd_n == fwd_tot) fwd_all = 1'b1;
    end
    if (done) begin done_cnt++; last_res = result; end
  end

  function automatic logic [31:0] word(int i, bit e, bit c);
    logic [31:0] w;
    w = 32'hA5C30000 ^ (i * 32'h00010203);
    if (i == 69) w[3:2] = e ? 2'b10 : 2'b00;
    if (i == 229) w[1] = ~c;
    return w;
  endfunction

  bit send_busy = 1'b0;
  task automatic send_all(int n, bit e, bit c);
    send_busy = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      img_valid = 1'b1; img_data = word(i, e, c); img_last = (i == n - 1);
      while (!img_ready) begin @(posedge clk); #2; end
    end
    @(posedge clk); #2;
    img_valid = 1'b0; img_last = 1'b0;
    send_busy = 1'b0;
  endtask

  // scenario settings
  bit s_enc, s_cmp, s_bump;
  int s_nw;
  logic [4:0] exp_prev = 5'b10000;

  task automatic defaults();
    full_mode = 0; mode_sel = 3'b000; cfg_n_in = 1; stat_n_in = 1; cfg_done_in = 1; user_mode = 1;
    s_nw = 0; s_enc = 0; s_cmp = 0; s_bump = 0;
    rdy_en = 1; rdy_at = 3; err_rdy = 0; err_at = 0; done_lvl = 1; err_done = 0;
  endtask

  task automatic put(logic [4:0] v);
    if (v != exp_prev) ex_q.push_back(int'(v));
    exp_prev = v;
  endtask

  task automatic build_trace();
    logic [4:0] c;
    c = exp_prev;
    c[4] = 0; c[1] = 0; c[0] = 0; put(c);
    c[3] = 1; put(c);
    c[2] = 1; put(c);
    c[1] = 1; put(c);
    ex_q.push_back(32'h1000 | 256);
    c[0] = 1; put(c);
    ex_q.push_back(32'h1000 | 2047);
    c[0] = 0; put(c);
    ex_q.push_back(32'h1000 | 256);
    c[3] = 0; put(c);
    c[4] = 1; put(c);
    c[1] = 0; put(c);
  endtask

  task automatic run(string tag, int exp_res, bit session, bit data_ok, int exp_ratio);
    int n;
    ev_q.delete(); ex_q.delete(); exp_q.delete();
    done_cnt = 0; fwd_n = 0; fwd_all = 0;
    fwd_tot = data_ok ? s_nw : -1;
    if (data_ok) for (int i = 0; i < s_nw; i++) exp_q.push_back(word(i, s_enc, s_cmp));
    if (session) build_trace();
    if (s_nw > 0) fork send_all(s_nw, s_enc, s_cmp); join_none
    @(posedge clk); #2 start = 1;
    @(posedge clk); #2 start = 0;
    if (s_bump) fork begin
      repeat (50) @(posedge clk);
      #2 start = 1;
      @(posedge clk); #2 start = 0;
    end join_none
    n = 0;
    while (done_cnt == 0 && n < 30000) begin @(negedge clk); n++; end
    chk(done_cnt > 0, "R11", {tag, " done seen"}, done_cnt, 1);
    chk(last_res == 2'(exp_res), tag, "result code", last_res, exp_res);
    repeat (80) @(negedge clk);
    chk(done_cnt == 1 && !busy, "R11", "one run only, start ignored when busy", done_cnt, 1);
    chk(result == 2'(exp_res), "R11", "result held", result, exp_res);
    chk(!send_busy, tag, "stream consumed", send_busy, 0);
    if (session) chk(clk_ratio == 2'(exp_ratio), "R4", "ratio code", clk_ratio, exp_ratio);
    chk(exp_q.size() == 0, "R6", "all words forwarded", exp_q.size(), 0);
    chk(ev_q.size() == ex_q.size(), "R5+R9", "port event count", ev_q.size(), ex_q.size());
    for (int i = 0; i < ev_q.size() && i < ex_q.size(); i++)
      chk(ev_q[i] == ex_q[i], "R5+R9", "port event", ev_q[i], ex_q[i]);
  endtask

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog: actual expired expected finished");
    finish_sim();
  end

  initial begin
    defaults();
    start = 0; img_valid = 0; img_last = 0; img_data = '0; out_ready = 1;
    rst_n = 0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(chip_en_n == 1, "R12", "chip enable idle", chip_en_n, 1);
    chk({drive_en, pin_release, port_own, pr_request} == 4'b0, "R12", "controls idle",
        {drive_en, pin_release, port_own, pr_request}, 0);
    chk(!busy && !done && !flush_req, "R12", "busy/done/flush idle", {busy, done, flush_req}, 0);
    chk(result == 2'd0, "R12", "result", result, 0);

    defaults(); full_mode = 1;                 run("R2", 1, 0, 0, 0);
    defaults(); mode_sel = 3'b010;             run("R1", 1, 0, 0, 0);
    defaults(); mode_sel = 3'b001; cfg_n_in = 0; run("R1", 1, 0, 0, 0);
    defaults(); stat_n_in = 0;                 run("R1", 1, 0, 0, 0);
    defaults(); s_nw = 100;                    run("R3", 1, 0, 0, 0);
    defaults(); s_nw = 240; s_bump = 1;        run("R10", 0, 1, 1, 0);
    defaults(); mode_sel = 3'b001; s_nw = 230; s_enc = 1; run("R3", 0, 1, 1, 1);
    defaults(); s_nw = 230; s_cmp = 1;         run("R4", 0, 1, 1, 2);
    defaults(); s_nw = 230; s_enc = 1; s_cmp = 1; run("R4", 0, 1, 1, 2);
    defaults(); s_nw = 230; rdy_at = 0; err_rdy = 1; err_at = 0; run("R7", 3, 1, 0, 0);
    defaults(); s_nw = 230; rdy_at = 9;        run("R7", 0, 1, 1, 0);
    defaults(); s_nw = 230; rdy_at = 10;       run("R7", 2, 1, 0, 0);
    defaults(); s_nw = 240; done_lvl = 0;      run("R8", 2, 1, 1, 0);
    defaults(); s_nw = 230; err_done = 1;      run("R8", 3, 1, 1, 0);
    defaults(); s_nw = 230; user_mode = 0;     run("R10", 2, 1, 1, 0);
    finish_sim();
  end
endmodule